// File: doc/BRIEF.md
# Control-Transfer Decoder and Cycle Timer

This block looks at one 8-bit opcode and the current flag byte and decides what the opcode does to program flow. It sorts the opcode into one of five transfer classes: direct jump, subroutine call, subroutine return, restart, or jump through HL. For a conditional opcode, it tests the flag named by the opcode's condition field and decides whether the transfer happens. It also reports how many machine cycles the instruction takes. That count depends on whether a conditional transfer is taken or falls through.

For every taken transfer, the block outputs a selector telling the sequencer where the next program counter comes from: the immediate operand, the stack, a fixed vector, or the HL pair. For restart opcodes it also outputs the vector address. The sequencer presents an opcode with a valid strobe and reads the registered result one clock later. The block does not fetch operands, touch the stack or hold the program counter.

Top module: `xfer_eval`

## Requirements
- R1: While `rst` is high, and after the first clock edge in reset, every output is zero.
- R2: When `op_valid` is high at a clock edge, the decode result appears on the outputs after that edge and `out_valid` is high. When `op_valid` is low at an edge, `out_valid` goes low and all other outputs keep their previous values.
- R3: The condition field is opcode bits 5:3. The tests are: 0 Z clear, 1 Z set, 2 CY clear, 3 CY set, 4 P clear, 5 P set, 6 S clear, 7 S set. The flag positions are S = bit 7, Z = bit 6, P = bit 2 and CY = bit 0.
- R4: Opcodes 11ccc010 are conditional jumps (kind 1). They take 10 cycles with next_src 1 (immediate) when the condition holds, and 7 cycles with next_src 0 (sequential) when it fails.
- R5: Opcodes 11ccc100 are conditional calls (kind 2). They take 18 cycles with next_src 1 when taken, and 9 cycles with next_src 0 when not taken.
- R6: Opcodes 11ccc000 are conditional returns (kind 3). They take 12 cycles with next_src 2 (stack) when taken, and 6 cycles with next_src 0 when not taken.
- R7: Three opcodes are unconditional and always taken, whatever the flags. 0xC3 is a jump (kind 1, 10 cycles, next_src 1). 0xCD is a call (kind 2, 18 cycles, next_src 1). 0xC9 is a return (kind 3, 10 cycles, next_src 2).
- R8: Opcodes 11nnn111 are restarts (kind 4). They are always taken, take 12 cycles, use next_src 3 (vector), and output vector = nnn × 8, giving 0x00 to 0x38. Every other opcode outputs vector 0.
- R9: Opcode 0xE9 is a jump through HL (kind 5). It is always taken, takes 6 cycles and uses next_src 4 (HL).
- R10: Any other opcode gives is_transfer 0, taken 0, kind 0, cycles 0, next_src 0 and vector 0. Any transfer opcode gives is_transfer 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Opcode and flags are present this cycle |
| opcode | input | 8 | Instruction opcode |
| flags | input | 8 | Current flag byte (S=7, Z=6, P=2, CY=0) |
| out_valid | output | 1 | Result of the previous cycle's opcode is valid |
| is_transfer | output | 1 | Opcode is a control transfer |
| taken | output | 1 | Transfer happens |
| kind | output | 3 | 0 none, 1 jump, 2 call, 3 return, 4 restart, 5 HL jump |
| cycles | output | 5 | Machine cycles used by the instruction |
| next_src | output | 3 | 0 sequential, 1 immediate, 2 stack, 3 vector, 4 HL |
| vector | output | 16 | Restart target address |

## Verification
There is one register stage between the inputs and the outputs, so any wrong decode shows on the port one clock after the opcode is strobed. A condition field routed to the wrong flag shows up only for some flag bytes. Because of this, each opcode is replayed against flag bytes that isolate each of the four tested bits, and also against all-zero and all-one bytes. A wrong taken/not-taken decision shows up on three outputs in the same cycle: taken, cycles and next_src.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

    localparam int OP_W  = 8;
    localparam int CYC_W = 5;

    localparam int FLG_S = 7;
    localparam int FLG_Z = 6;
    localparam int FLG_P = 2;
    localparam int FLG_C = 0;

    localparam logic [OP_W-1:0] OP_JMP  = 8'hC3;
    localparam logic [OP_W-1:0] OP_CALL = 8'hCD;
    localparam logic [OP_W-1:0] OP_RET  = 8'hC9;
    localparam logic [OP_W-1:0] OP_HLJ  = 8'hE9;

    typedef enum logic [2:0] {
        K_NONE = 3'd0,
        K_JUMP = 3'd1,
        K_CALL = 3'd2,
        K_RET  = 3'd3,
        K_RST  = 3'd4,
        K_HLJ  = 3'd5
    } xfer_kind_e;

    typedef enum logic [2:0] {
        SRC_SEQ = 3'd0,
        SRC_IMM = 3'd1,
        SRC_STK = 3'd2,
        SRC_VEC = 3'd3,
        SRC_HL  = 3'd4
    } pc_src_e;

    typedef struct packed {
        xfer_kind_e kind;
        logic       conditional;
        logic [2:0] field;
    } op_class_t;

    typedef struct packed {
        logic             is_xfer;
        logic             taken;
        xfer_kind_e       kind;
        logic [CYC_W-1:0] cycles;
        pc_src_e          src;
    } xfer_res_t;

    function automatic logic [CYC_W-1:0] pick_cycles(input logic hit,
                                                     input int   yes,
                                                     input int   no);
        return hit ? CYC_W'(yes) : CYC_W'(no);
    endfunction

endpackage

// File: rtl/cond_eval.sv
module cond_eval
    import xfer_pkg::*;
(
    input  logic [2:0]      field,
    input  logic [OP_W-1:0] flags,
    output logic            pass
);
    logic [3:0] unused_flag_bits;
    logic       base;

    assign unused_flag_bits = {flags[5], flags[4], flags[3], flags[1]};

    always_comb begin
        unique case (field[2:1])
            2'd0:    base = flags[FLG_Z];
            2'd1:    base = flags[FLG_C];
            2'd2:    base = flags[FLG_P];
            default: base = flags[FLG_S];
        endcase
        pass = field[0] ? base : ~base;
    end
endmodule

// File: rtl/op_classify.sv
module op_classify
    import xfer_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output op_class_t       cls
);
    always_comb begin
        cls.kind        = K_NONE;
        cls.conditional = 1'b0;
        cls.field       = opcode[5:3];
        if (opcode == OP_JMP) begin
            cls.kind = K_JUMP;
        end else if (opcode == OP_CALL) begin
            cls.kind = K_CALL;
        end else if (opcode == OP_RET) begin
            cls.kind = K_RET;
        end else if (opcode == OP_HLJ) begin
            cls.kind = K_HLJ;
        end else if (opcode[7:6] == 2'b11) begin
            unique case (opcode[2:0])
                3'b010: begin cls.kind = K_JUMP; cls.conditional = 1'b1; end
                3'b100: begin cls.kind = K_CALL; cls.conditional = 1'b1; end
                3'b000: begin cls.kind = K_RET;  cls.conditional = 1'b1; end
                3'b111: cls.kind = K_RST;
                default: cls.kind = K_NONE;
            endcase
        end
    end
endmodule

// File: rtl/cycle_table.sv
module cycle_table
    import xfer_pkg::*;
(
    input  op_class_t cls,
    input  logic      pass,
    output xfer_res_t res
);
    logic hit;

    always_comb begin
        hit         = ~cls.conditional | pass;
        res.is_xfer = (cls.kind != K_NONE);
        res.taken   = res.is_xfer & hit;
        res.kind    = cls.kind;
        res.cycles  = '0;
        res.src     = SRC_SEQ;
        unique case (cls.kind)
            K_JUMP: begin
                res.cycles = pick_cycles(hit, 10, 7);
                res.src    = hit ? SRC_IMM : SRC_SEQ;
            end
            K_CALL: begin
                res.cycles = pick_cycles(hit, 18, 9);
                res.src    = hit ? SRC_IMM : SRC_SEQ;
            end
            K_RET: begin
                res.cycles = cls.conditional ? pick_cycles(hit, 12, 6) : CYC_W'(10);
                res.src    = hit ? SRC_STK : SRC_SEQ;
            end
            K_RST: begin
                res.cycles = CYC_W'(12);
                res.src    = SRC_VEC;
            end
            K_HLJ: begin
                res.cycles = CYC_W'(6);
                res.src    = SRC_HL;
            end
            default: begin
                res.cycles = '0;
                res.src    = SRC_SEQ;
            end
        endcase
    end
endmodule

// File: rtl/xfer_eval.sv
module xfer_eval
    import xfer_pkg::*;
#(
    parameter int VEC_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 op_valid,
    input  logic [OP_W-1:0]      opcode,
    input  logic [OP_W-1:0]      flags,
    output logic                 out_valid,
    output logic                 is_transfer,
    output logic                 taken,
    output logic [2:0]           kind,
    output logic [CYC_W-1:0]     cycles,
    output logic [2:0]           next_src,
    output logic [VEC_W-1:0]     vector
);
    localparam int VEC_SHIFT = 3;

    op_class_t        cls;
    logic             pass;
    xfer_res_t        res;
    logic [VEC_W-1:0] vec_next;

    op_classify u_cls  (.opcode(opcode), .cls(cls));
    cond_eval   u_cond (.field(cls.field), .flags(flags), .pass(pass));
    cycle_table u_tab  (.cls(cls), .pass(pass), .res(res));

    assign vec_next = (cls.kind == K_RST)
                    ? (VEC_W'(cls.field) << VEC_SHIFT) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            is_transfer <= 1'b0;
            taken       <= 1'b0;
            kind        <= '0;
            cycles      <= '0;
            next_src    <= '0;
            vector      <= '0;
        end else begin
            out_valid <= op_valid;
            if (op_valid) begin
                is_transfer <= res.is_xfer;
                taken       <= res.taken;
                kind        <= res.kind;
                cycles      <= res.cycles;
                next_src    <= res.src;
                vector      <= vec_next;
            end
        end
    end

    // R10
    taken_needs_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        taken |-> is_transfer);

    // R10
    idle_op_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !is_transfer |-> (cycles == '0) && (next_src == SRC_SEQ) && (vector == '0));

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> out_valid);

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> $stable(cycles) && $stable(next_src) && $stable(kind));

    // R4
    fallthrough_seq_chk: assert property (@(posedge clk) disable iff (rst)
        (is_transfer && !taken) |-> (next_src == SRC_SEQ));

    // R8
    vector_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        (kind == K_RST) |-> (vector[2:0] == 3'd0) && (vector < VEC_W'(8'h40)));
endmodule

// File: tb/xfer_eval_bench.sv
module xfer_eval_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [7:0]  flags = 8'h00;
    logic        out_valid, is_transfer, taken;
    logic [2:0]  kind, next_src;
    logic [4:0]  cycles;
    logic [15:0] vector;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    int e_x = 0, e_t = 0, e_k = 0, e_c = 0, e_s = 0, e_v = 0;
    string e_tag = "R10";

    always #(CLK_PERIOD/2) clk = ~clk;

    xfer_eval u_xfer_eval (
        .clk(clk), .rst(rst), .op_valid(op_valid), .opcode(opcode), .flags(flags),
        .out_valid(out_valid), .is_transfer(is_transfer), .taken(taken), .kind(kind),
        .cycles(cycles), .next_src(next_src), .vector(vector)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit cond_ok(input int c, input int fl);
        bit z = fl[6], cy = fl[0], p = fl[2], s = fl[7];
        case (c)
            0: return !z;  1: return z;
            2: return !cy; 3: return cy;
            4: return !p;  5: return p;
            6: return !s;  default: return s;
        endcase
    endfunction

    // behavioural reference: R3..R10
    task automatic model(input int op, input int fl);
        int c = (op >> 3) & 7;
        int lo = op & 7;
        bit hit;
        e_x = 0; e_t = 0; e_k = 0; e_c = 0; e_s = 0; e_v = 0; e_tag = "R10";
        if (op == 'hC3) begin e_tag = "R7"; e_x = 1; e_t = 1; e_k = 1; e_c = 10; e_s = 1; end
        else if (op == 'hCD) begin e_tag = "R7"; e_x = 1; e_t = 1; e_k = 2; e_c = 18; e_s = 1; end
        else if (op == 'hC9) begin e_tag = "R7"; e_x = 1; e_t = 1; e_k = 3; e_c = 10; e_s = 2; end
        else if (op == 'hE9) begin e_tag = "R9"; e_x = 1; e_t = 1; e_k = 5; e_c = 6; e_s = 4; end
        else if ((op >> 6) == 3) begin
            hit = cond_ok(c, fl);
            if (lo == 2) begin
                e_tag = "R4"; e_x = 1; e_k = 1; e_t = hit;
                e_c = hit ? 10 : 7; e_s = hit ? 1 : 0;
            end else if (lo == 4) begin
                e_tag = "R5"; e_x = 1; e_k = 2; e_t = hit;
                e_c = hit ? 18 : 9; e_s = hit ? 1 : 0;
            end else if (lo == 0) begin
                e_tag = "R6"; e_x = 1; e_k = 3; e_t = hit;
                e_c = hit ? 12 : 6; e_s = hit ? 2 : 0;
            end else if (lo == 7) begin
                e_tag = "R8"; e_x = 1; e_t = 1; e_k = 4; e_c = 12; e_s = 3; e_v = c * 8;
            end
        end
    endtask

    task automatic compare_all(input int exp_valid);
        chk("R2", "out_valid", int'(out_valid), exp_valid);
        chk(e_tag, "is_transfer", int'(is_transfer), e_x);
        chk(e_tag, "taken (R3 condition)", int'(taken), e_t);
        chk(e_tag, "kind", int'(kind), e_k);
        chk(e_tag, "cycles", int'(cycles), e_c);
        chk(e_tag, "next_src", int'(next_src), e_s);
        chk(e_tag, "vector", int'(vector), e_v);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        int flag_set [7] = '{8'h00, 8'hFF, 8'h40, 8'h01, 8'h04, 8'h80, 8'hBA};
        int prev_valid = 0;
        int n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        compare_all(0);
        rst = 1'b0;
        for (int f = 0; f < 7; f++) begin
            for (int op = 0; op < 256; op++) begin
                @(negedge clk);
                if (n > 0) compare_all(prev_valid);
                n++;
                if ((n % 5) == 0) begin
                    // R2: idle cycle, outputs must hold
                    op_valid = 1'b0;
                    opcode = 8'hC3;
                    flags = 8'h00;
                    prev_valid = 0;
                    @(negedge clk);
                    compare_all(prev_valid);
                end
                op_valid = 1'b1;
                opcode = 8'(op);
                flags = 8'(flag_set[f]);
                model(op, flag_set[f]);
                prev_valid = 1;
            end
        end
        @(negedge clk);
        compare_all(prev_valid);
        op_valid = 1'b0;
        @(negedge clk);
        compare_all(0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule